// File: doc/BRIEF.md
# Parity-Protected Queue Adapter for a Parity-Free Bus

This block sits between a bus that has no parity wires and a memory controller whose datapath carries byte parity. Parity exists only inside the adapter, so data waiting in its queues stays protected.

Write data taken from the bus gets one even-parity bit per byte as it enters. Data and parity then go into a write queue and leave toward memory in arrival order. Read data arrives from the memory side with its byte parity already attached and is held in a read queue. Each read entry is checked as it is popped. A good entry is driven onto the bus as normal response data. A bad entry becomes a target-abort response, and the remaining beats of that burst are dropped from the queue.

A sticky error flag and the byte-lane mask of the first failing beat stay visible on output pins until reset.

Top module: `parq_adapter`

## Requirements
- R1: For every entry offered toward memory, each bit k of `mem_wr_par` is even parity of data bits [8k+7:8k]: it equals the XOR of those eight bits.
- R2: Write entries reach the memory side with their data unchanged and in the order the bus supplied them. While `mem_wr_ready` is low, the offered entry holds steady.
- R3: The write queue holds 8 entries. When it is full, `wq_full` is high, `bus_wr_ready` is low and no bus write is taken.
- R4: The read queue holds 8 entries. When it is full, `rq_full` is high, `mem_rd_ready` is low and no memory beat is taken.
- R5: A popped read entry whose stored parity matches its data is delivered with its data and last marker, and with `bus_rsp_abort` low. A stalled response holds steady.
- R6: A popped read entry with any parity mismatch is delivered as a target abort: `bus_rsp_abort` high, `bus_rsp_last` high and `bus_rsp_data` zero.
- R7: After an abort on a beat that was not the last of its burst, every following beat up to and including the burst's last beat is removed from the read queue and never delivered. The next burst is delivered normally.
- R8: `err_flag` rises in the cycle after the first aborted response is accepted and stays high until reset.
- R9: `err_lanes` holds the mismatch mask of the first failing beat, with bit k meaning byte lane k. Later failures leave it unchanged.
- R10: After reset both queues are empty: `wq_empty` and `rq_empty` are high, and `mem_wr_valid`, `bus_rsp_valid`, `err_flag` and `err_lanes` are zero.
- R11: `bus_rsp_valid` is high exactly when the read queue is non-empty and no discard is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_valid | input | 1 | Bus offers a write word |
| bus_wr_ready | output | 1 | Write queue can take a word |
| bus_wr_data | input | 32 | Write word from the bus (no parity) |
| mem_wr_valid | output | 1 | Write entry offered to memory |
| mem_wr_ready | input | 1 | Memory takes the write entry |
| mem_wr_data | output | 32 | Write entry data |
| mem_wr_par | output | 4 | Write entry byte parity |
| mem_rd_valid | input | 1 | Memory offers a read beat |
| mem_rd_ready | output | 1 | Read queue can take a beat |
| mem_rd_data | input | 32 | Read beat data |
| mem_rd_par | input | 4 | Read beat byte parity |
| mem_rd_last | input | 1 | Read beat closes its burst |
| bus_rsp_valid | output | 1 | Response offered on the bus |
| bus_rsp_ready | input | 1 | Bus takes the response |
| bus_rsp_data | output | 32 | Response data (zero on abort) |
| bus_rsp_last | output | 1 | Response closes the burst |
| bus_rsp_abort | output | 1 | Response is a target abort |
| wq_full | output | 1 | Write queue full |
| wq_empty | output | 1 | Write queue empty |
| rq_full | output | 1 | Read queue full |
| rq_empty | output | 1 | Read queue empty |
| err_flag | output | 1 | Sticky parity error flag |
| err_lanes | output | 4 | Failing byte lanes of the first error |

## Verification
The hardest case to reach is a discard that runs ahead of the memory side. A beat fails early in a burst, and the rest of that burst has not yet arrived, so the adapter sits in its drop state with an empty read queue. The stimulus reaches this case by injecting a parity fault on the first beat of a burst while the memory source offers beats only about a third of the time. A good burst follows so that the bench can confirm normal delivery resumes. A further fault on a burst's final beat checks that no discard starts when the abort already ends the burst, and that the captured lane mask keeps its first value.

// File: rtl/parq_pkg.sv
package parq_pkg;

    localparam int unsigned PQ_DATA_W = 32;
    localparam int unsigned PQ_LANES  = PQ_DATA_W / 8;
    localparam int unsigned PQ_DEPTH  = 8;

    typedef logic [PQ_DATA_W-1:0] word_t;
    typedef logic [PQ_LANES-1:0]  lane_t;

    // entry held in the write queue
    typedef struct packed {
        word_t data;
        lane_t par;
    } wr_ent_t;

    // entry held in the read queue
    typedef struct packed {
        word_t data;
        lane_t par;
        logic  last;
    } rd_ent_t;

    typedef enum logic [0:0] {
        RD_PASS = 1'b0,
        RD_DROP = 1'b1
    } rd_mode_e;

    // even parity per byte lane: bit equals XOR of the lane's bits
    function automatic lane_t lane_parity(word_t w);
        lane_t p;
        for (int i = 0; i < int'(PQ_LANES); i++) begin
            p[i] = ^w[8*i +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/parq_lane_parity.sv
module parq_lane_parity #(
    parameter int unsigned LANES = 4,
    localparam int unsigned W = LANES * 8
) (
    input  logic [W-1:0]     data,
    output logic [LANES-1:0] par
);

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign par[g] = ^data[8*g +: 8];
    end

endmodule

// File: rtl/parq_fifo.sv
module parq_fifo #(
    parameter int unsigned WIDTH = 36,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt == CNT_W'(DEPTH));
    assign empty    = (cnt == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = store[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= push_data;
    end

endmodule

// File: rtl/parq_rd_ctrl.sv
module parq_rd_ctrl
    import parq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rd_ent_t head,
    input  logic    q_empty,
    output logic    q_pop,
    input  logic    rsp_ready,
    output logic    rsp_valid,
    output word_t   rsp_data,
    output logic    rsp_last,
    output logic    rsp_abort,
    output logic    err,
    output lane_t   err_mask
);

    rd_mode_e mode;
    lane_t    calc_par;
    lane_t    mism;
    logic     bad, deliver, drop;

    parq_lane_parity #(.LANES(PQ_LANES)) u_check (
        .data (head.data),
        .par  (calc_par)
    );

    assign mism      = calc_par ^ head.par;
    assign bad       = |mism;
    assign rsp_valid = !q_empty && (mode == RD_PASS);
    assign rsp_abort = rsp_valid && bad;
    assign rsp_data  = bad ? '0 : head.data;
    assign rsp_last  = bad || head.last;
    assign deliver   = rsp_valid && rsp_ready;
    assign drop      = (mode == RD_DROP) && !q_empty;
    assign q_pop     = deliver || drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= RD_PASS;
            err      <= 1'b0;
            err_mask <= '0;
        end else begin
            case (mode)
                RD_PASS: if (deliver && bad && !head.last) mode <= RD_DROP;
                RD_DROP: if (drop && head.last)            mode <= RD_PASS;
                default: mode <= RD_PASS;
            endcase
            if (deliver && bad && !err) begin
                err      <= 1'b1;
                err_mask <= mism;
            end
        end
    end

endmodule

// File: rtl/parq_adapter.sv
module parq_adapter
    import parq_pkg::*;
#(
    parameter int unsigned DEPTH = PQ_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr_valid,
    output logic                 bus_wr_ready,
    input  logic [PQ_DATA_W-1:0] bus_wr_data,
    output logic                 mem_wr_valid,
    input  logic                 mem_wr_ready,
    output logic [PQ_DATA_W-1:0] mem_wr_data,
    output logic [PQ_LANES-1:0]  mem_wr_par,
    input  logic                 mem_rd_valid,
    output logic                 mem_rd_ready,
    input  logic [PQ_DATA_W-1:0] mem_rd_data,
    input  logic [PQ_LANES-1:0]  mem_rd_par,
    input  logic                 mem_rd_last,
    output logic                 bus_rsp_valid,
    input  logic                 bus_rsp_ready,
    output logic [PQ_DATA_W-1:0] bus_rsp_data,
    output logic                 bus_rsp_last,
    output logic                 bus_rsp_abort,
    output logic                 wq_full,
    output logic                 wq_empty,
    output logic                 rq_full,
    output logic                 rq_empty,
    output logic                 err_flag,
    output logic [PQ_LANES-1:0]  err_lanes
);

    localparam int unsigned WQ_W = $bits(wr_ent_t);
    localparam int unsigned RQ_W = $bits(rd_ent_t);

    // ---------------- write path ----------------
    wr_ent_t wr_in, wr_out;
    lane_t   wr_gen_par;

    parq_lane_parity #(.LANES(PQ_LANES)) u_wr_gen (
        .data (bus_wr_data),
        .par  (wr_gen_par)
    );

    assign wr_in.data = bus_wr_data;
    assign wr_in.par  = wr_gen_par;

    parq_fifo #(.WIDTH(WQ_W), .DEPTH(DEPTH)) u_wq (
        .clk       (clk),
        .rst       (rst),
        .push      (bus_wr_valid),
        .push_data (wr_in),
        .pop       (mem_wr_valid && mem_wr_ready),
        .pop_data  (wr_out),
        .full      (wq_full),
        .empty     (wq_empty)
    );

    assign bus_wr_ready = !wq_full;
    assign mem_wr_valid = !wq_empty;
    assign mem_wr_data  = wr_out.data;
    assign mem_wr_par   = wr_out.par;

    // ---------------- read path ----------------
    rd_ent_t rd_in, rd_head;
    logic    rd_pop;

    assign rd_in.data = mem_rd_data;
    assign rd_in.par  = mem_rd_par;
    assign rd_in.last = mem_rd_last;

    parq_fifo #(.WIDTH(RQ_W), .DEPTH(DEPTH)) u_rq (
        .clk       (clk),
        .rst       (rst),
        .push      (mem_rd_valid),
        .push_data (rd_in),
        .pop       (rd_pop),
        .pop_data  (rd_head),
        .full      (rq_full),
        .empty     (rq_empty)
    );

    assign mem_rd_ready = !rq_full;

    parq_rd_ctrl u_rd_ctrl (
        .clk       (clk),
        .rst       (rst),
        .head      (rd_head),
        .q_empty   (rq_empty),
        .q_pop     (rd_pop),
        .rsp_ready (bus_rsp_ready),
        .rsp_valid (bus_rsp_valid),
        .rsp_data  (bus_rsp_data),
        .rsp_last  (bus_rsp_last),
        .rsp_abort (bus_rsp_abort),
        .err       (err_flag),
        .err_mask  (err_lanes)
    );

endmodule

// File: rtl/parq_adapter_chk.sv
module parq_adapter_chk
    import parq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr_ready,
    input logic                 mem_wr_valid,
    input logic                 mem_wr_ready,
    input logic [PQ_DATA_W-1:0] mem_wr_data,
    input logic [PQ_LANES-1:0]  mem_wr_par,
    input logic                 mem_rd_ready,
    input logic                 bus_rsp_valid,
    input logic                 bus_rsp_ready,
    input logic [PQ_DATA_W-1:0] bus_rsp_data,
    input logic                 bus_rsp_last,
    input logic                 bus_rsp_abort,
    input logic                 wq_full,
    input logic                 rq_full,
    input logic                 rq_empty,
    input logic                 err_flag,
    input logic [PQ_LANES-1:0]  err_lanes
);

    assert_wr_parity_R1: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> (mem_wr_par == lane_parity(mem_wr_data)));

    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        wq_full |-> !bus_wr_ready);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        rq_full |-> !mem_rd_ready);

    assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && !bus_rsp_ready) |=> (bus_rsp_valid && $stable(bus_rsp_data)));

    assert_abort_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && bus_rsp_abort) |-> (bus_rsp_last && bus_rsp_data == '0));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && bus_rsp_ready && bus_rsp_abort) |=> err_flag);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    assert_lanes_kept_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> $stable(err_lanes));

    assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        rq_empty |-> !bus_rsp_valid);

endmodule

bind parq_adapter parq_adapter_chk u_parq_chk (.*);

// File: tb/tb_parq_adapter.sv
module tb_parq_adapter;

    localparam int DEPTH = 8;

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  p;
        logic        l;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_valid = 1'b0, bus_wr_ready;
    logic [31:0] bus_wr_data = '0;
    logic        mem_wr_valid, mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_par;
    logic        mem_rd_valid = 1'b0, mem_rd_ready;
    logic [31:0] mem_rd_data = '0;
    logic [3:0]  mem_rd_par = '0;
    logic        mem_rd_last = 1'b0;
    logic        bus_rsp_valid, bus_rsp_ready = 1'b0;
    logic [31:0] bus_rsp_data;
    logic        bus_rsp_last, bus_rsp_abort;
    logic        wq_full, wq_empty, rq_full, rq_empty, err_flag;
    logic [3:0]  err_lanes;

    always #10 clk = ~clk; // 50 MHz

    parq_adapter #(.DEPTH(DEPTH)) dut (.*);

    int checks = 0, fails = 0;

    // reference model state
    logic [31:0] mwq[$];
    beat_t       mrq[$];
    logic [31:0] wsrc[$];
    beat_t       rsrc[$];
    bit          dropping = 0, merr = 0;
    logic [3:0]  mlanes = '0;
    int          p_wv = 100, p_wr = 100, p_rv = 100, p_rr = 100;
    int          rsp_count = 0;

    function automatic logic [3:0] par4(logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic add_burst(int n, int bad_idx, logic [3:0] flip);
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.d = $urandom();
            b.p = par4(b.d) ^ ((i == bad_idx) ? flip : 4'b0000);
            b.l = (i == n - 1);
            rsrc.push_back(b);
        end
    endtask

    task automatic add_writes(int n);
        for (int i = 0; i < n; i++) wsrc.push_back($urandom());
    endtask

    task automatic cycle();
        bit         exp_wrdy, exp_rrdy, exp_rv, wpush, wpop, rpush;
        logic [3:0] mism;
        beat_t      b;
        @(negedge clk);
        bus_wr_valid  = (wsrc.size() > 0) && ($urandom_range(99) < p_wv);
        bus_wr_data   = (wsrc.size() > 0) ? wsrc[0] : '0;
        mem_wr_ready  = ($urandom_range(99) < p_wr);
        mem_rd_valid  = (rsrc.size() > 0) && ($urandom_range(99) < p_rv);
        b             = (rsrc.size() > 0) ? rsrc[0] : '0;
        mem_rd_data   = b.d;
        mem_rd_par    = b.p;
        mem_rd_last   = b.l;
        bus_rsp_ready = ($urandom_range(99) < p_rr);
        #1;
        exp_wrdy = mwq.size() < DEPTH;
        exp_rrdy = mrq.size() < DEPTH;
        exp_rv   = (mrq.size() > 0) && !dropping;
        chk(bus_wr_ready === exp_wrdy, "R3 bus_wr_ready", 64'(bus_wr_ready), 64'(exp_wrdy));
        chk(wq_full === (mwq.size() == DEPTH), "R3 wq_full", 64'(wq_full), 64'(mwq.size() == DEPTH));
        chk(wq_empty === (mwq.size() == 0), "R10 wq_empty", 64'(wq_empty), 64'(mwq.size() == 0));
        chk(mem_wr_valid === (mwq.size() > 0), "R2 mem_wr_valid", 64'(mem_wr_valid), 64'(mwq.size() > 0));
        if (mwq.size() > 0) begin
            chk(mem_wr_data === mwq[0], "R2 mem_wr_data", 64'(mem_wr_data), 64'(mwq[0]));
            chk(mem_wr_par === par4(mwq[0]), "R1 mem_wr_par", 64'(mem_wr_par), 64'(par4(mwq[0])));
        end
        chk(mem_rd_ready === exp_rrdy, "R4 mem_rd_ready", 64'(mem_rd_ready), 64'(exp_rrdy));
        chk(rq_full === (mrq.size() == DEPTH), "R4 rq_full", 64'(rq_full), 64'(mrq.size() == DEPTH));
        chk(rq_empty === (mrq.size() == 0), "R10 rq_empty", 64'(rq_empty), 64'(mrq.size() == 0));
        chk(bus_rsp_valid === exp_rv, dropping ? "R7 rsp_valid in discard" : "R11 rsp_valid",
            64'(bus_rsp_valid), 64'(exp_rv));
        if (exp_rv) begin
            mism = mrq[0].p ^ par4(mrq[0].d);
            if (mism != 0) begin
                chk(bus_rsp_abort === 1'b1, "R6 abort", 64'(bus_rsp_abort), 64'd1);
                chk(bus_rsp_last === 1'b1 && bus_rsp_data === '0, "R6 abort last/data",
                    {31'd0, bus_rsp_last, bus_rsp_data}, {31'd0, 1'b1, 32'd0});
            end else begin
                chk(bus_rsp_abort === 1'b0, "R5 abort low", 64'(bus_rsp_abort), 64'd0);
                chk(bus_rsp_data === mrq[0].d && bus_rsp_last === mrq[0].l, "R5 data/last",
                    {31'd0, bus_rsp_last, bus_rsp_data}, {31'd0, mrq[0].l, mrq[0].d});
            end
        end
        chk(err_flag === merr, "R8 err_flag", 64'(err_flag), 64'(merr));
        chk(err_lanes === mlanes, "R9 err_lanes", 64'(err_lanes), 64'(mlanes));

        // model update for the coming edge
        wpush = bus_wr_valid && exp_wrdy;
        wpop  = mem_wr_ready && (mwq.size() > 0);
        rpush = mem_rd_valid && exp_rrdy;
        if (wpop) void'(mwq.pop_front());
        if (wpush) begin
            mwq.push_back(bus_wr_data);
            void'(wsrc.pop_front());
        end
        if (dropping && mrq.size() > 0) begin
            b = mrq.pop_front();
            if (b.l) dropping = 0;
        end else if (exp_rv && bus_rsp_ready) begin
            b = mrq.pop_front();
            rsp_count++;
            mism = b.p ^ par4(b.d);
            if (mism != 0) begin
                if (!merr) begin
                    merr   = 1;
                    mlanes = mism;
                end
                if (!b.l) dropping = 1;
            end
        end
        if (rpush) mrq.push_back(rsrc.pop_front());
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic drain(int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (wsrc.size() == 0 && rsrc.size() == 0 && mwq.size() == 0 && mrq.size() == 0 && !dropping)
                break;
            cycle();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk(wq_empty === 1'b1 && rq_empty === 1'b1, "R10 queues empty after reset",
            {wq_empty, rq_empty}, 64'd3);
        chk(mem_wr_valid === 1'b0 && bus_rsp_valid === 1'b0, "R10 no valids after reset",
            {mem_wr_valid, bus_rsp_valid}, 64'd0);
        chk(err_flag === 1'b0 && err_lanes === 4'd0, "R10 error state after reset",
            {err_flag, err_lanes}, 64'd0);

        // R3, R1, R2: fill write queue with memory stalled, then drain
        add_writes(11);
        p_wr = 0;
        run(15);
        p_wr = 100;
        drain(100);
        p_wr = 50; p_wv = 70;
        add_writes(20);
        drain(300);
        p_wr = 100; p_wv = 100;

        // R5: clean burst
        add_burst(4, -1, 4'b0);
        drain(100);

        // R4: fill read queue with the bus stalled
        add_burst(6, -1, 4'b0);
        add_burst(6, -1, 4'b0);
        p_rr = 0;
        run(15);
        p_rr = 100;
        drain(100);

        // R6, R7, R8, R9: fault on second beat, then a clean burst
        rsp_count = 0;
        add_burst(5, 1, 4'b0101);
        add_burst(3, -1, 4'b0);
        drain(200);
        chk(rsp_count == 5, "R7 beats delivered around discard", 64'(rsp_count), 64'd5);

        // R7: discard waiting on a slow memory source
        rsp_count = 0;
        p_rv = 30;
        add_burst(4, 0, 4'b1000);
        add_burst(2, -1, 4'b0);
        drain(400);
        chk(rsp_count == 3, "R7 slow-source discard", 64'(rsp_count), 64'd3);
        p_rv = 100;

        // R9: later fault on final beat keeps first mask, no discard
        rsp_count = 0;
        add_burst(3, 2, 4'b0010);
        add_burst(2, -1, 4'b0);
        drain(200);
        chk(rsp_count == 5, "R6 abort on last beat ends burst", 64'(rsp_count), 64'd5);
        chk(err_lanes === 4'b0101, "R9 first mask kept", 64'(err_lanes), 64'(4'b0101));

        // mixed traffic
        p_wv = 60; p_wr = 55; p_rv = 65; p_rr = 50;
        for (int k = 0; k < 60; k++) begin
            int n;
            n = $urandom_range(6, 1);
            if ($urandom_range(7) == 0)
                add_burst(n, $urandom_range(n - 1), 4'($urandom_range(15, 1)));
            else
                add_burst(n, -1, 4'b0);
            add_writes($urandom_range(4));
            run(20);
        end
        p_wv = 100; p_wr = 100; p_rv = 100; p_rr = 100;
        drain(2000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule